// File: doc/BRIEF.md
# Write-programmable trigger delay generator

This block places a single output pulse a programmable number of clock cycles after a trigger edge. An 8-bit delay code is captured from a parallel data bus under a write strobe. A rising edge on the trigger input, taken only while the active-low enable is low, starts a delay cycle. A cycle counter counts from the accepted edge. When it reaches a fixed minimum offset plus the captured code, the block drives one pulse of fixed width, returns to idle and can accept the next trigger.

The trigger, enable and write inputs are asynchronous to the clock. Each passes through a two-flop synchroniser before any edge is detected. The data bus must be held stable while the write strobe is high and for two clock cycles after it falls. The code is copied into the timer at the accepted trigger, so a write made during a running cycle takes effect only from the next trigger.

Top module: `trig_delay_gen`

## Requirements
- R1: The delay code is read as an unsigned binary value with bit 0 as its least significant bit. If trig is first sampled high at clock edge X, out rises after edge X + 2 + MIN_OFS + code.
- R2: Every pulse on out lasts exactly PULSE_W clock cycles, whatever the code.
- R3: out_n is always the inverse of out, and after reset out is 0 and out_n is 1.
- R4: While write is high the stored code follows d, delayed by the synchroniser, so a trigger given while write is still high uses the current d.
- R5: The stored code keeps the value d had when write fell. Changes on d while write is low have no effect.
- R6: A trigger rising edge at which ce_n is high is ignored, and no pulse follows.
- R7: Only a rising edge of trig starts a cycle. Holding trig high produces exactly one pulse.
- R8: A trig rising edge that arrives while busy is high is ignored and does not restart or extend the cycle.
- R9: The code is copied at the accepted trigger. A write during a running cycle changes only the delay of the next cycle.
- R10: busy is high from the cycle after the trigger is accepted until the pulse ends, and is high during the whole pulse. A trigger given as soon as busy drops is accepted.
- R11: After reset, busy and out are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Asynchronous trigger; a rising edge starts a delay cycle |
| ce_n | input | 1 | Active-low enable, sampled at the trigger edge |
| write | input | 1 | Write strobe; the code follows d while high and is held after it falls |
| d | input | CODE_W | Delay code, bit 0 least significant |
| out | output | 1 | Delayed output pulse |
| out_n | output | 1 | Inverse of out |
| busy | output | 1 | A delay cycle or pulse is in progress |

## Verification
The bench builds the block with CODE_W = 8, MIN_OFS = 3 and PULSE_W = 4. The short offset keeps a zero code within a few cycles of the trigger, so the shortest delay is cheap to check. The 4-cycle pulse makes a wrong pulse width visible. With an 8-bit code, all-ones (a wait of 258 cycles) stays well inside the run. Long codes of 64 and 80 leave enough time to issue a second trigger, or to complete a full write, while a cycle is still running.

// File: rtl/trig_delay_pkg.sv
// Shared types for the trigger delay generator.
package trig_delay_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/dg_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous level inputs.
// Assumes each bit is independent; bits may resolve on different cycles.
module dg_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], async_i};
    end

    assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/dg_code_latch.sv
// Delay-code store: follows the data bus while the synchronised write
// strobe is high and holds the last value once it drops.
// Assumes d is stable from write rising until two cycles after it falls.
module dg_code_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] code_q
);
    // Track d while load is high, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    code_q <= '0;
        else if (load) code_q <= d;
    end
endmodule

// File: rtl/dg_delay_timer.sv
// Delay cycle timer: on start (when idle) copies the code, waits
// MIN_OFS + code cycles, then drives a pulse of PULSE_W cycles.
// Assumes MIN_OFS >= 1 and PULSE_W >= 1; start while busy is ignored.
module dg_delay_timer
    import trig_delay_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int MIN_OFS = 3,
    parameter int PULSE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    output logic              busy,
    output logic              pulse
);
    localparam int CNT_W = $clog2(MIN_OFS + (2 ** CODE_W) + PULSE_W + 1);

    tmr_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] snap_q;
    logic [CNT_W-1:0]  wait_last;

    // Final count value of the waiting phase for the copied code.
    always_comb wait_last = CNT_W'(MIN_OFS) + CNT_W'(snap_q) - CNT_W'(1);

    // Sequence idle -> wait -> pulse -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            snap_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_WAIT;
                    cnt    <= '0;
                    snap_q <= code;
                end
                ST_WAIT: if (cnt == wait_last) begin
                    state <= ST_PULSE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
                ST_PULSE: if (cnt == CNT_W'(PULSE_W - 1)) begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy  = (state != ST_IDLE);
    assign pulse = (state == ST_PULSE);
endmodule

// File: rtl/trig_delay_gen.sv
// Top of the write-programmable trigger delay generator.
// Synchronises trig/ce_n/write, detects the trigger rising edge,
// qualifies it with the enable and drives the delay timer.
module trig_delay_gen #(
    parameter int CODE_W  = 8,
    parameter int MIN_OFS = 3,
    parameter int PULSE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              ce_n,
    input  logic              write,
    input  logic [CODE_W-1:0] d,
    output logic              out,
    output logic              out_n,
    output logic              busy
);
    logic [2:0]        raw_bus, sync_bus;
    logic              trig_s, write_s, ce_n_s;
    logic              trig_prev, trig_rise, accept;
    logic [CODE_W-1:0] code_q;
    logic              pulse;

    assign raw_bus = {ce_n, write, trig};

    dg_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_bus), .sync_o(sync_bus)
    );

    assign {ce_n_s, write_s, trig_s} = sync_bus;

    // Remember last synchronised trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_prev <= 1'b0;
        else        trig_prev <= trig_s;
    end

    assign trig_rise = trig_s & ~trig_prev;
    assign accept    = trig_rise & ~ce_n_s;

    dg_code_latch #(.W(CODE_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .load(write_s), .d(d), .code_q(code_q)
    );

    dg_delay_timer #(.CODE_W(CODE_W), .MIN_OFS(MIN_OFS), .PULSE_W(PULSE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(accept), .code(code_q),
        .busy(busy), .pulse(pulse)
    );

    assign out   = pulse;
    assign out_n = ~pulse;
endmodule

// File: rtl/dg_delay_timer_chk.sv
// Property checker for the delay timer, attached by bind.
module dg_delay_timer_chk #(
    parameter int CODE_W  = 8,
    parameter int MIN_OFS = 3,
    parameter int PULSE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              pulse,
    input logic [CODE_W-1:0] snap_q
);
    localparam int CNT_W = $clog2(MIN_OFS + (2 ** CODE_W) + PULSE_W + 1);

    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] hi_cnt;

    // Cycles spent waiting since the cycle was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)              elapsed <= '0;
        else if (busy && !pulse) elapsed <= elapsed + CNT_W'(1);
        else                     elapsed <= '0;
    end

    // Cycles the pulse has been high so far.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_cnt <= '0;
        else if (pulse) hi_cnt <= hi_cnt + CNT_W'(1);
        else            hi_cnt <= '0;
    end

    assert_delay_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> (elapsed == CNT_W'(MIN_OFS) + CNT_W'(snap_q)));

    assert_pulse_not_long_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (hi_cnt < CNT_W'(PULSE_W)));

    assert_pulse_full_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> (hi_cnt == CNT_W'(PULSE_W)));

    assert_cycle_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_snap_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(snap_q));

    assert_idle_after_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> !busy);
endmodule

bind dg_delay_timer dg_delay_timer_chk #(
    .CODE_W(CODE_W), .MIN_OFS(MIN_OFS), .PULSE_W(PULSE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .pulse(pulse), .snap_q(snap_q)
);

// File: tb/trig_delay_gen_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected pulse cycles, a monitor
// pops and compares them when out rises.
module trig_delay_gen_test;
    localparam int CODE_W  = 8;
    localparam int MIN_OFS = 3;
    localparam int PULSE_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic trig = 1'b0, ce_n = 1'b0, write = 1'b0;
    logic [CODE_W-1:0] d = '0;
    logic out, out_n, busy;

    int cyc = 0, n_checks = 0, n_fail = 0, pulses = 0;
    int exp_q[$];
    bit done = 0;

    trig_delay_gen #(.CODE_W(CODE_W), .MIN_OFS(MIN_OFS), .PULSE_W(PULSE_W)) uut (
        .clk(clk), .rst_n(rst_n), .trig(trig), .ce_n(ce_n), .write(write),
        .d(d), .out(out), .out_n(out_n), .busy(busy)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Store a code through the write strobe.
    task automatic load(input logic [CODE_W-1:0] v);
        @(negedge clk); d = v; write = 1'b1;
        repeat (3) @(negedge clk);
        write = 1'b0;
        repeat (4) @(negedge clk);
        d = ~v;
    endtask

    // Raise trig for hold cycles; queue the expected rise cycle if accepted.
    task automatic fire(input int code, input bit en_high, input bit accepted, input int hold);
        @(negedge clk);
        trig = 1'b1; ce_n = en_high;
        if (accepted) exp_q.push_back(cyc + 3 + MIN_OFS + code);
        repeat (hold) @(negedge clk);
        trig = 1'b0; ce_n = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // Monitor: compare pulse timing, width and companion outputs.
    int width = 0;
    logic out_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (out && !out_prev) begin
                pulses++;
                chk(out_n == 1'b0, "R3 out_n inverse", out_n, 0);
                chk(busy == 1'b1, "R10 busy during pulse", busy, 1);
                if (exp_q.size() == 0) chk(1'b0, "R6/R7/R8 unexpected pulse", cyc, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cyc == e, "R1 pulse rise cycle", cyc, e);
                end
            end
            if (out) width++;
            if (!out && out_prev) begin
                chk(width == PULSE_W, "R2 pulse width", width, PULSE_W);
                width = 0;
            end
            out_prev = out;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            finish_run();
        end
    end

    initial begin
        int p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 / R3: reset state
        chk(out == 1'b0, "R11 out after reset", out, 0);
        chk(busy == 1'b0, "R11 busy after reset", busy, 0);
        chk(out_n == 1'b1, "R3 out_n after reset", out_n, 1);

        // R1: code extremes and mixed bits
        load(8'h00); fire(0, 0, 1, 4); wait_idle();
        load(8'h01); fire(1, 0, 1, 4); wait_idle();
        load(8'hA5); fire(165, 0, 1, 4); wait_idle();
        load(8'hFF); fire(255, 0, 1, 4); wait_idle();

        // R6: enable high at the edge
        load(8'h05);
        p0 = pulses;
        fire(5, 1, 0, 4);
        repeat (40) @(negedge clk);
        chk(pulses == p0, "R6 disabled trigger pulses", pulses - p0, 0);
        chk(busy == 1'b0, "R6 disabled trigger busy", busy, 0);

        // R7: trig held high across a whole cycle
        load(8'h10);
        p0 = pulses;
        fire(16, 0, 1, 60);
        repeat (40) @(negedge clk);
        chk(pulses - p0 == 1, "R7 held trigger pulses", pulses - p0, 1);

        // R8: second edge while busy
        load(8'h50);
        p0 = pulses;
        fire(80, 0, 1, 4);
        repeat (20) @(negedge clk);
        fire(80, 0, 0, 4);
        wait_idle();
        repeat (20) @(negedge clk);
        chk(pulses - p0 == 1, "R8 busy retrigger pulses", pulses - p0, 1);

        // R9: write during a running cycle
        load(8'h40);
        fire(64, 0, 1, 4);
        load(8'h08);
        chk(busy == 1'b1, "R9 write inside cycle", busy, 1);
        wait_idle();
        fire(8, 0, 1, 4); wait_idle();

        // R5: d changes while write is low are ignored
        @(negedge clk); d = 8'hEE;
        repeat (5) @(negedge clk);
        fire(8, 0, 1, 4); wait_idle();

        // R4: trigger while write is still high uses current d
        @(negedge clk); write = 1'b1; d = 8'h22;
        repeat (5) @(negedge clk); d = 8'h33;
        repeat (5) @(negedge clk);
        fire(51, 0, 1, 4); wait_idle();
        write = 1'b0;
        repeat (5) @(negedge clk);

        // R10: back-to-back trigger as soon as busy drops
        load(8'h02);
        fire(2, 0, 1, 4); wait_idle();
        fire(2, 0, 1, 4); wait_idle();
        repeat (10) @(negedge clk);

        chk(exp_q.size() == 0, "R1 all expected pulses seen", exp_q.size(), 0);
        done = 1;
        finish_run();
    end
endmodule